// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block is the register front end of a multi-function peripheral. The host reaches it through a window of two byte addresses on a simple synchronous I/O bus. The low address is an index port and the high address is a data port. The host writes a register number to the index port, then reads or writes that register through the data port.

The configuration space starts out closed. It opens only after the host writes a key byte to the index port twice in a row. It closes again when the host writes an exit byte to the index port. While it is open, a selector register picks one of several logical devices. Register numbers below 0x30 are global to the whole peripheral. Register 0x30 holds the activate flag of the selected device. Higher register numbers belong to the selected device: the block keeps no storage for them and passes each such access to the device as a one-cycle strobe.

Top module: `cfg_unlock_ctrl`

## Requirements
- R1: After reset the configuration space is closed, the index and selector registers hold 0, every device activate flag is 0, io_rdata is 0x00 and dev_stb is low.
- R2: The space opens only when two index-port writes of 0x87 arrive with no other index-port write between them. Any other index-port write after the first 0x87 sends the sequence back to its start. Data-port traffic and index-port reads neither advance the sequence nor reset it.
- R3: While the space is open, an index-port write of 0xAA closes it and leaves the index register unchanged. Any other index-port write loads the index register, and an index-port read returns that register.
- R4: While the space is closed, data-port writes change no state, and a read of either port returns 0xFF.
- R5: Index 0x07 is the device selector. A write stores the low DEV_W bits of the data byte, and a read returns them zero-extended.
- R6: A read of index 0x20 returns the DEV_ID parameter (default 0xC1), and writes to it are ignored.
- R7: Indices 0x29 to 0x2D are five independent read/write byte registers that reset to 0x00. Every other global index (below 0x30, apart from 0x07 and 0x20) reads 0x00 and ignores writes.
- R8: Bit 0 of index 0x30 is the activate flag of the selected device, and it drives dev_active[sel]. Bits 7..1 read as 0, and the flags of the other devices are not touched.
- R9: An open data-port access at index 0x31 or above raises dev_stb for exactly that cycle. In that cycle dev_num carries the selector, dev_idx the index, dev_we the direction and dev_wdata the written byte. On a read, dev_rdata is captured in that same cycle.
- R10: io_rdata changes only in the cycle after a read, and holds its value until the next read.
- R11: When io_wr and io_rd are high in the same cycle, the write takes effect (including any device strobe, with dev_we=1) and the read is ignored, so io_rdata holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| dev_stb | output | 1 | One-cycle strobe for a device register access |
| dev_we | output | 1 | Direction of the device access (1 = write) |
| dev_num | output | DEV_W | Selected device number |
| dev_idx | output | 8 | Register index of the device access |
| dev_wdata | output | 8 | Write data for the device |
| dev_rdata | input | 8 | Read data returned by the device in the strobe cycle |
| dev_active | output | N_DEV | Activate flags, one per device |

## Verification
The write strobe and the read strobe can both be high in the same cycle. The bench drives that case on a global register, on the activate register and on a device-owned register. In each case the reference model applies the write and keeps the previous read data, and every clock the model is compared with io_rdata, dev_active and the device strobe fields. A second collision is a key byte arriving while the space is already open. The bench writes 0x87 in that state and checks that it only loads the index and does not close or re-arm the space.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam logic [7:0] KEY_ENTER = 8'h87;
    localparam logic [7:0] KEY_EXIT  = 8'hAA;
    localparam logic [7:0] IDX_SEL   = 8'h07;
    localparam logic [7:0] IDX_ID    = 8'h20;
    localparam logic [7:0] IDX_PM_LO = 8'h29;
    localparam logic [7:0] IDX_PM_HI = 8'h2D;
    localparam logic [7:0] IDX_ACT   = 8'h30;
    localparam logic [7:0] IDX_BANK  = 8'h31;
    localparam int         PM_N      = int'(IDX_PM_HI - IDX_PM_LO) + 1;
    localparam logic [7:0] RD_CLOSED = 8'hFF;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_e;

    typedef enum logic [1:0] {
        RG_GLOBAL = 2'd0,
        RG_ACT    = 2'd1,
        RG_BANK   = 2'd2
    } region_e;

    function automatic region_e region_of(input logic [7:0] idx);
        if (idx < IDX_ACT)       return RG_GLOBAL;
        else if (idx == IDX_ACT) return RG_ACT;
        else                     return RG_BANK;
    endfunction

    function automatic logic is_pinmux(input logic [7:0] idx);
        return (idx >= IDX_PM_LO) && (idx <= IDX_PM_HI);
    endfunction
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open,
    output logic       idx_load
);
    lock_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                LK_IDLE: state_d = (wdata == KEY_ENTER) ? LK_HALF : LK_IDLE;
                LK_HALF: state_d = (wdata == KEY_ENTER) ? LK_OPEN : LK_IDLE;
                LK_OPEN: state_d = (wdata == KEY_EXIT)  ? LK_IDLE : LK_OPEN;
                default: state_d = LK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LK_IDLE;
        else     state_q <= state_d;
    end

    assign cfg_open = (state_q == LK_OPEN);
    assign idx_load = idx_wr && cfg_open && (wdata != KEY_EXIT);
endmodule

// File: rtl/cfg_global_bank.sv
module cfg_global_bank
    import cfg_pkg::*;
#(
    parameter int         DEV_W  = 3,
    parameter logic [7:0] DEV_ID = 8'hC1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       idx,
    input  logic [7:0]       wdata,
    output logic [DEV_W-1:0] sel,
    output logic [7:0]       rdata
);
    logic [7:0]       pm_q [PM_N];
    logic [DEV_W-1:0] sel_q;
    logic [2:0]       pm_off;

    assign pm_off = 3'(idx - IDX_PM_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr_en && idx == IDX_SEL) begin
            sel_q <= wdata[DEV_W-1:0];
        end
    end

    for (genvar g = 0; g < PM_N; g++) begin : g_pm
        always_ff @(posedge clk) begin
            if (rst)
                pm_q[g] <= 8'h00;
            else if (wr_en && is_pinmux(idx) && pm_off == 3'(g))
                pm_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (idx == IDX_SEL)     rdata = 8'(sel_q);
        else if (idx == IDX_ID) rdata = DEV_ID;
        else if (is_pinmux(idx)) begin
            for (int i = 0; i < PM_N; i++)
                if (pm_off == 3'(i)) rdata = pm_q[i];
        end
    end

    assign sel = sel_q;
endmodule

// File: rtl/cfg_act_bank.sv
module cfg_act_bank #(
    parameter int N_DEV = 8,
    parameter int DEV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wbit,
    input  logic [DEV_W-1:0] sel,
    output logic [N_DEV-1:0] active,
    output logic             act_sel
);
    for (genvar g = 0; g < N_DEV; g++) begin : g_act
        always_ff @(posedge clk) begin
            if (rst)
                active[g] <= 1'b0;
            else if (wr_en && sel == DEV_W'(g))
                active[g] <= wbit;
        end
    end

    always_comb begin
        act_sel = 1'b0;
        for (int i = 0; i < N_DEV; i++)
            if (sel == DEV_W'(i)) act_sel = active[i];
    end
endmodule

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl
    import cfg_pkg::*;
#(
    parameter int         N_DEV  = 8,
    parameter logic [7:0] DEV_ID = 8'hC1,
    localparam int        DEV_W  = (N_DEV > 2) ? $clog2(N_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             io_addr,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic             dev_stb,
    output logic             dev_we,
    output logic [DEV_W-1:0] dev_num,
    output logic [7:0]       dev_idx,
    output logic [7:0]       dev_wdata,
    input  logic [7:0]       dev_rdata,
    output logic [N_DEV-1:0] dev_active
);
    logic             cfg_open, idx_load;
    logic [7:0]       idx_q, glob_rdata, rdata_q;
    logic [DEV_W-1:0] sel_q;
    logic             act_sel;
    logic             rd_op, data_wr, data_rd;
    region_e          region;

    assign rd_op   = io_rd && !io_wr;
    assign data_wr = io_wr && io_addr && cfg_open;
    assign data_rd = rd_op && io_addr && cfg_open;
    assign region  = region_of(idx_q);

    cfg_key_fsm u_key (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (io_wr && !io_addr),
        .wdata    (io_wdata),
        .cfg_open (cfg_open),
        .idx_load (idx_load)
    );

    cfg_global_bank #(.DEV_W(DEV_W), .DEV_ID(DEV_ID)) u_glob (
        .clk   (clk),
        .rst   (rst),
        .wr_en (data_wr && region == RG_GLOBAL),
        .idx   (idx_q),
        .wdata (io_wdata),
        .sel   (sel_q),
        .rdata (glob_rdata)
    );

    cfg_act_bank #(.N_DEV(N_DEV), .DEV_W(DEV_W)) u_act (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (data_wr && region == RG_ACT),
        .wbit    (io_wdata[0]),
        .sel     (sel_q),
        .active  (dev_active),
        .act_sel (act_sel)
    );

    always_ff @(posedge clk) begin
        if (rst)           idx_q <= 8'h00;
        else if (idx_load) idx_q <= io_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= 8'h00;
        end else if (rd_op) begin
            if (!cfg_open)              rdata_q <= RD_CLOSED;
            else if (!io_addr)          rdata_q <= idx_q;
            else if (region == RG_GLOBAL) rdata_q <= glob_rdata;
            else if (region == RG_ACT)  rdata_q <= {7'b0, act_sel};
            else                        rdata_q <= dev_rdata;
        end
    end

    assign io_rdata  = rdata_q;
    assign dev_stb   = (data_wr || data_rd) && region == RG_BANK;
    assign dev_we    = io_wr;
    assign dev_num   = sel_q;
    assign dev_idx   = idx_q;
    assign dev_wdata = io_wdata;
endmodule

// File: rtl/cfg_unlock_chk.sv
module cfg_unlock_chk #(
    parameter int N_DEV = 8,
    parameter int DEV_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             io_addr,
    input logic             io_wr,
    input logic             io_rd,
    input logic [7:0]       io_wdata,
    input logic [7:0]       io_rdata,
    input logic             dev_stb,
    input logic [7:0]       dev_idx,
    input logic [N_DEV-1:0] dev_active,
    input logic             cfg_open,
    input logic [DEV_W-1:0] sel_q
);
    p_stb_gated_r9: assert property (@(posedge clk) disable iff (rst)
        dev_stb |-> (cfg_open && io_addr && (io_wr || io_rd) && dev_idx >= 8'h31));

    p_closed_read_r4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && io_rd && !io_wr) |=> io_rdata == 8'hFF);

    p_closed_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |=> ($stable(dev_active) && $stable(sel_q)));

    p_exit_key_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && io_wr && !io_addr && io_wdata == 8'hAA) |=> !cfg_open);

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && !io_wr) |=> $stable(io_rdata));

    p_open_by_key_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(io_wr && !io_addr && io_wdata == 8'h87));
endmodule

bind cfg_unlock_ctrl cfg_unlock_chk #(.N_DEV(N_DEV), .DEV_W(DEV_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .dev_stb    (dev_stb),
    .dev_idx    (dev_idx),
    .dev_active (dev_active),
    .cfg_open   (cfg_open),
    .sel_q      (sel_q)
);

// File: tb/tb_cfg_unlock_ctrl.sv
module tb_cfg_unlock_ctrl;
    localparam int CLK_P = 10;
    localparam logic [7:0] ID = 8'hC1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_addr = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       dev_stb, dev_we;
    logic [2:0] dev_num;
    logic [7:0] dev_idx, dev_wdata, dev_rdata;
    logic [7:0] dev_active;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string cur_req = "R1";

    // reference model state
    int         m_stage = 0;
    logic [7:0] m_idx = 8'h00;
    logic [2:0] m_sel = 3'd0;
    logic [7:0] m_pm [5];
    logic [7:0] m_act = 8'h00;
    logic [7:0] m_rd = 8'h00;

    always #(CLK_P/2) clk = ~clk;

    // device stub: deterministic read data from number and index
    assign dev_rdata = dev_idx ^ 8'h5A ^ {5'b0, dev_num};

    cfg_unlock_ctrl #(.N_DEV(8), .DEV_ID(ID)) dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_stb(dev_stb), .dev_we(dev_we),
        .dev_num(dev_num), .dev_idx(dev_idx), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .dev_active(dev_active)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic a);
        if (m_stage != 2) return 8'hFF;
        if (!a) return m_idx;
        if (m_idx == 8'h07) return {5'b0, m_sel};
        if (m_idx == 8'h20) return ID;
        if (m_idx >= 8'h29 && m_idx <= 8'h2D) return m_pm[m_idx - 8'h29];
        if (m_idx < 8'h30) return 8'h00;
        if (m_idx == 8'h30) return {7'b0, m_act[m_sel]};
        return m_idx ^ 8'h5A ^ {5'b0, m_sel};
    endfunction

    task automatic m_step(input logic a, input logic w, input logic r, input logic [7:0] d);
        if (w) begin
            if (!a) begin
                if (m_stage == 2) begin
                    if (d == 8'hAA) m_stage = 0;
                    else m_idx = d;
                end else if (m_stage == 1) m_stage = (d == 8'h87) ? 2 : 0;
                else m_stage = (d == 8'h87) ? 1 : 0;
            end else if (m_stage == 2) begin
                if (m_idx == 8'h07) m_sel = d[2:0];
                else if (m_idx >= 8'h29 && m_idx <= 8'h2D) m_pm[m_idx - 8'h29] = d;
                else if (m_idx == 8'h30) m_act[m_sel] = d[0];
            end
        end else if (r) begin
            m_rd = m_read(a);
        end
    endtask

    // one bus cycle; entered and left at a falling edge
    task automatic cyc(input logic a, input logic w, input logic r, input logic [7:0] d);
        logic exp_stb;
        io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
        #1;
        exp_stb = (m_stage == 2) && a && (w || r) && (m_idx >= 8'h31);
        chk("dev_stb", 32'(dev_stb), 32'(exp_stb));
        if (exp_stb) begin
            chk("dev_we", 32'(dev_we), 32'(w));
            chk("dev_num", 32'(dev_num), 32'(m_sel));
            chk("dev_idx", 32'(dev_idx), 32'(m_idx));
            if (w) chk("dev_wdata", 32'(dev_wdata), 32'(d));
        end
        @(posedge clk);
        m_step(a, w, r, d);
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        chk("io_rdata", 32'(io_rdata), 32'(m_rd));
        chk("dev_active", 32'(dev_active), 32'(m_act));
    endtask

    task automatic wi(input logic [7:0] d); cyc(1'b0, 1'b1, 1'b0, d); endtask
    task automatic wd(input logic [7:0] d); cyc(1'b1, 1'b1, 1'b0, d); endtask
    task automatic rd_d(); cyc(1'b1, 1'b0, 1'b1, 8'h00); endtask
    task automatic rd_i(); cyc(1'b0, 1'b0, 1'b1, 8'h00); endtask
    task automatic idle(); cyc(1'b0, 1'b0, 1'b0, 8'h00); endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) m_pm[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        cur_req = "R1";
        chk("io_rdata reset", 32'(io_rdata), 32'h00);
        chk("dev_active reset", 32'(dev_active), 32'h00);
        idle(); idle();
        // R4: closed space
        cur_req = "R4";
        rd_d(); rd_i();
        wi(8'h07); wd(8'h03); wi(8'h30); wd(8'h01); rd_d();
        // R2: broken key sequences
        cur_req = "R2";
        wi(8'h87); wi(8'h12); wi(8'h87); rd_d();
        wi(8'h87); wd(8'h55); rd_i(); wi(8'h87); rd_i();
        // R3: index register and key while open
        cur_req = "R3";
        wi(8'h87); rd_i();
        // R5: selector
        cur_req = "R5";
        wi(8'h07); wd(8'h05); rd_d(); wd(8'hFE); rd_d(); wd(8'h03); rd_d();
        // R6: identifier
        cur_req = "R6";
        wi(8'h20); rd_d(); wd(8'h00); rd_d();
        // R7: pin-multiplex and other globals
        cur_req = "R7";
        for (int k = 0; k < 5; k++) begin
            wi(8'h29 + 8'(k)); rd_d(); wd(8'hA0 + 8'(k)); rd_d();
        end
        wi(8'h2B); rd_d();
        wi(8'h28); wd(8'h77); rd_d(); wi(8'h2E); wd(8'h66); rd_d(); wi(8'h00); rd_d();
        // R8: activate flags
        cur_req = "R8";
        wi(8'h30); wd(8'hFF); rd_d(); wd(8'hFE); rd_d(); wd(8'h01);
        wi(8'h07); wd(8'h06); wi(8'h30); rd_d(); wd(8'h03); rd_d();
        // R9: forwarded device accesses
        cur_req = "R9";
        wi(8'h45); wd(8'h9C); rd_d(); wi(8'h31); rd_d(); wi(8'hF0); wd(8'h11); rd_d();
        // R10: read data holds across other traffic
        cur_req = "R10";
        idle(); wd(8'h22); wi(8'h2A); idle(); rd_d();
        // R11: simultaneous strobes
        cur_req = "R11";
        cyc(1'b1, 1'b1, 1'b1, 8'h5D); rd_d();
        wi(8'h30); cyc(1'b1, 1'b1, 1'b1, 8'h00); rd_d();
        wi(8'h50); cyc(1'b1, 1'b1, 1'b1, 8'h3C); rd_d();
        // R3: exit and re-entry keeps state
        cur_req = "R3";
        wi(8'hAA); rd_i(); rd_d(); wd(8'h44);
        cur_req = "R4";
        wi(8'h07); wd(8'h01); rd_d();
        cur_req = "R2";
        wi(8'h87); wi(8'h87); rd_i();
        cur_req = "R3";
        wi(8'h2A); rd_d(); wi(8'h07); rd_d();
        idle();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule